// File: doc/BRIEF.md
# Reversible Maximal-Period Address Stepper

This block generates addresses and patterns for a memory self-test engine. It is a three-stage shift register with feedback. A correction term, formed as the NOR of the stages that do not feed back, pulls the register through the all-zero word. As a result, every one of the eight possible words appears exactly once per period.

A single direction input chooses one of two shift paths. In the forward path the register shifts toward the high stage and follows the characteristic polynomial x^3 + x + 1. In the reverse path it shifts toward the low stage and follows the reciprocal polynomial x^3 + x^2 + 1. The reverse order is the exact mirror of the forward order, so a march sequencer can walk the same address set ascending and then descending. Each stage has its own 2:1 selector, and the direction input steers all of them.

The sequencer asserts the enable input for each step and holds it low to freeze the current address. Memory access, march control and response checking belong to other blocks.

Top module: `updn_lfsr_stepper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `state` becomes 0 on that edge. Reset takes priority over `en` and `up`.
- R2: When `en` is low at a rising edge (and reset is inactive), `state` keeps its value.
- R3: With `en` high and `up` high, each edge advances `state` (bit i holds stage Xi) through 0, 1, 3, 7, 6, 5, 2, 4 and back to 0. This order is a left-to-right shift from bit 0 toward bit 2, with feedback into bit 0.
- R4: With `en` high and `up` low, each edge advances `state` through 0, 4, 2, 5, 6, 7, 3, 1 and back to 0. This order is a shift from bit 2 toward bit 0, with feedback into bit 2.
- R5: For every one of the 8 states, one enabled step with `up` high followed by one enabled step with `up` low returns `state` to its starting value.
- R6: A change of `up` takes effect on the next enabled edge. That step goes from the current state to its neighbour in the new direction, and no state is skipped or repeated.
- R7: Eight consecutive enabled steps in one direction visit 8 distinct values, including 0, and return to the starting value. An enabled step never leaves `state` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, loads 0 |
| en | input | 1 | Step enable; low holds the state |
| up | input | 1 | 1 selects the forward order, 0 selects the reverse order |
| state | output | 3 | Current address/pattern word, bit i is stage Xi |

## Verification
Two behaviours can fall on the same edge: a reset and an enabled step, and a reversal of direction together with a step. The stimulus table asserts reset while `en` and `up` are high, and it flips `up` in the middle of walks in both directions. On the reset edge the output must read 0. On a reversal edge it must read the predecessor of the current state in the old order. A directed loop starts from each of the eight states and applies a forward step immediately followed by a reverse step. The output must land back on the starting word.

// File: rtl/updn_lfsr_pkg.sv
// Package: shared types for the reversible address stepper.
// Assumes: one direction bit, where 1 means forward (toward the high stage).
package updn_lfsr_pkg;

    // Direction of one shift step
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;

endpackage

// File: rtl/updn_lfsr_fb.sv
// Module: updn_lfsr_fb
// Computes both feedback bits from the present state.
// Forward feedback enters the low stage and uses the taps (HI, TAP), plus the
// NOR of stages 0..HI-1. Reverse feedback enters the high stage and uses the
// mirrored taps (0, TAP+1), plus the NOR of stages 1..HI.
// Assumes: a single-tap feedback polynomial, with TAP+1 <= WIDTH-1.
module updn_lfsr_fb #(
    parameter int WIDTH = 3,
    parameter int TAP   = 0
) (
    input  logic [WIDTH-1:0] cur,
    output logic             fb_up,
    output logic             fb_dn
);
    localparam int HI     = WIDTH - 1;
    localparam int TAP_DN = TAP + 1;

    // Forward and reverse feedback, each with its zero-state correction
    always_comb begin
        fb_up = cur[HI] ^ cur[TAP]    ^ ~(|cur[HI-1:0]);
        fb_dn = cur[0]  ^ cur[TAP_DN] ^ ~(|cur[HI:1]);
    end
endmodule

// File: rtl/updn_lfsr_stage_mux.sv
// Module: updn_lfsr_stage_mux
// One 2:1 selector per stage, which picks the value loaded into that stage.
// Forward: stage i takes stage i-1, and stage 0 takes fb_up.
// Reverse: stage i takes stage i+1, and stage HI takes fb_dn.
// Assumes: WIDTH >= 2.
module updn_lfsr_stage_mux
    import updn_lfsr_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             fb_up,
    input  logic             fb_dn,
    input  step_dir_e        dir,
    output logic [WIDTH-1:0] nxt
);
    localparam int HI = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_lo;
        logic from_hi;

        if (i == 0) begin : g_lo_end
            assign from_lo = fb_up;
        end else begin : g_lo_mid
            assign from_lo = cur[i-1];
        end

        if (i == HI) begin : g_hi_end
            assign from_hi = fb_dn;
        end else begin : g_hi_mid
            assign from_hi = cur[i+1];
        end

        // Per-stage selector steered by the direction
        always_comb begin
            nxt[i] = (dir == STEP_UP) ? from_lo : from_hi;
        end
    end
endmodule

// File: rtl/updn_lfsr_stepper.sv
// Module: updn_lfsr_stepper (top)
// Reversible shift register that covers all 2^WIDTH states, the all-zero word
// included. It is used as the memory self-test address and pattern stepper.
// Assumes: synchronous active-low reset; en qualifies every step; the default
// TAP gives x^3+x+1 forward and x^3+x^2+1 in reverse.
module updn_lfsr_stepper
    import updn_lfsr_pkg::*;
#(
    parameter int WIDTH = 3,
    parameter int TAP   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up,
    output logic [WIDTH-1:0] state
);
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt;
    logic             fb_up;
    logic             fb_dn;
    step_dir_e        dir;

    // Map the raw direction pin onto the shared type
    always_comb begin
        dir = up ? STEP_UP : STEP_DOWN;
    end

    updn_lfsr_fb #(
        .WIDTH (WIDTH),
        .TAP   (TAP)
    ) u_fb (
        .cur   (cur_q),
        .fb_up (fb_up),
        .fb_dn (fb_dn)
    );

    updn_lfsr_stage_mux #(
        .WIDTH (WIDTH)
    ) u_mux (
        .cur   (cur_q),
        .fb_up (fb_up),
        .fb_dn (fb_dn),
        .dir   (dir),
        .nxt   (nxt)
    );

    // State register: reset to zero, otherwise step when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (en) begin
            cur_q <= nxt;
        end
    end

    assign state = cur_q;
endmodule

// File: rtl/updn_lfsr_stepper_chk.sv
// Module: updn_lfsr_stepper_chk
// Assertions on the stepper's ports, attached through bind.
// Assumes: the same WIDTH as the bound instance.
module updn_lfsr_stepper_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             up,
    input logic [WIDTH-1:0] state
);
    localparam int HI = WIDTH - 1;

    // R1: the first cycle after reset shows zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> state == '0);

    // R2: a disabled edge keeps the state
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> state == $past(state));

    // R3: a forward step shifts the low stages up by one
    a_r3_up_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && $past(up)) |-> state[HI:1] == $past(state[HI-1:0]));

    // R4: a reverse step shifts the high stages down by one
    a_r4_down_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !$past(up)) |-> state[HI-1:0] == $past(state[HI:1]));

    // R7: an enabled step always changes the state, including from zero
    a_r7_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |-> state != $past(state));
endmodule

bind updn_lfsr_stepper updn_lfsr_stepper_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .up    (up),
    .state (state)
);

// File: tb/updn_lfsr_stepper_tb.sv
module updn_lfsr_stepper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 25;

    // Vector: {rst_n, en, up, expected[2:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b0_1_1_000,  // reset
        6'b1_1_1_001, 6'b1_1_1_011, 6'b1_1_1_111, 6'b1_1_1_110,
        6'b1_1_1_101, 6'b1_1_1_010, 6'b1_1_1_100, 6'b1_1_1_000,
        6'b1_0_1_000,  // hold
        6'b1_1_0_100, 6'b1_1_0_010, 6'b1_1_0_101,
        6'b1_0_0_101,  // hold
        6'b1_1_0_110, 6'b1_1_0_111, 6'b1_1_0_011, 6'b1_1_0_001,
        6'b1_1_0_000,
        6'b1_1_1_001, 6'b1_1_1_011,
        6'b1_1_0_001,  // reverse mid walk
        6'b1_1_1_011,  // forward again
        6'b1_0_1_011,
        6'b0_1_1_000   // reset wins over a step
    };

    localparam logic [2:0] UP_ORDER [8] = '{3'd0, 3'd1, 3'd3, 3'd7, 3'd6, 3'd5, 3'd2, 3'd4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       up = 1'b1;
    logic [2:0] state;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_lfsr_stepper u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .up    (up),
        .state (state)
    );

    task automatic check(input string req, input logic [2:0] exp);
        checks++;
        if (state !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, state, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic u);
        @(negedge clk);
        rst_n = r; en = e; up = u;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic prev_up;
        logic [2:0] start;
        prev_up = 1'b1;
        step(1'b0, 1'b0, 1'b1);
        check("R1", 3'd0);

        for (int k = 0; k < NVEC; k++) begin
            string tag;
            step(VEC[k][5], VEC[k][4], VEC[k][3]);
            if (!VEC[k][5])                tag = "R1";
            else if (!VEC[k][4])           tag = "R2";
            else if (VEC[k][3] != prev_up) tag = "R6";
            else if (VEC[k][3])            tag = "R3";
            else                           tag = "R4";
            if (VEC[k][5] && VEC[k][4]) prev_up = VEC[k][3];
            check(tag, VEC[k][2:0]);
        end

        // R5: from each state, one forward step then one reverse step
        for (int s = 0; s < 8; s++) begin
            step(1'b0, 1'b0, 1'b1);
            for (int j = 0; j < s; j++) step(1'b1, 1'b1, 1'b1);
            check("R3", UP_ORDER[s]);
            start = state;
            step(1'b1, 1'b1, 1'b1);
            check("R3", UP_ORDER[(s + 1) % 8]);
            step(1'b1, 1'b1, 1'b0);
            check("R5", start);
        end

        // R7: eight reverse steps from an arbitrary start, all distinct
        begin
            logic [7:0] seen;
            logic [2:0] origin;
            seen = '0;
            origin = state;
            for (int j = 0; j < 8; j++) begin
                step(1'b1, 1'b1, 1'b0);
                checks++;
                if (seen[state]) begin
                    errors++;
                    $display("FAIL R7 actual=repeat of %0d expected=new value", state);
                end
                seen[state] = 1'b1;
            end
            check("R7", origin);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule